// File: doc/BRIEF.md
# VGA 640x480 Raster Timing Generator

This block produces the scan timing for a 640x480 progressive display refreshed at about 60 Hz. It runs on the system clock and advances one pixel position on each cycle in which the pixel-rate enable is high, which is nominally 25 MHz. Its outputs are a horizontal and a vertical sync pulse, the current column and row, and a flag that is high while the position is inside the visible picture. Logic further up the design uses the column and row to choose what to draw and uses the flag to gate its colour.

An 8-bit colour path is included. The colour is packed with red in bits [7:5], green in bits [4:2] and blue in bits [1:0]. On every enabled edge the block captures the colour input and sends it to the colour output if the new position is visible. If the new position is not visible, the output is forced to zero (black). The raster never stalls. Because no back-pressure exists, the colour input carries no valid/ready handshake: the upstream logic must present the colour for the next position before each enabled edge.

The column and row count from 0, and 0 is the first visible pixel and line. A line is 640 visible pixels, then 16 of front porch, 96 of sync and 48 of back porch, for 800 in total. A frame is 480 visible lines, then 10 of front porch, 2 of sync and 33 of back porch, for 525 in total. All of these are parameters. Both syncs default to active-low. Each sync polarity is a parameter, so modes that use positive-true syncs are also supported. Every output comes from a register.

Top module: `vga_raster_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to the last position of the frame. This gives `hcount_o`=799 and `vcount_o`=524, both syncs at their inactive level, `active_o`=0 and `pix_out_o`=0. The first enabled edge after reset therefore moves to column 0, row 0.
- R2: On each enabled edge `hcount_o` increases by one. On the edge after it reaches H_TOTAL-1 (799), it wraps to 0.
- R3: `vcount_o` changes only on the enabled edge where `hcount_o` wraps. On that edge it increases by one, or wraps from V_TOTAL-1 (524) to 0.
- R4: `hsync_o` is at its active level exactly while `hcount_o` is in 656..751. It keeps pulsing on every line, including the lines in vertical sync.
- R5: `vsync_o` is at its active level exactly while `vcount_o` is in 490..491. It changes level only when `hcount_o` is 0.
- R6: `active_o` is 1 exactly when `hcount_o` < 640 and `vcount_o` < 480.
- R7: After an enabled edge, `pix_out_o` equals the `pix_in` value sampled on that edge if the new position is visible, and is 0 otherwise. The three colour fields pass through unchanged.
- R8: When the polarity parameters are left at their defaults (0), both syncs are low while active and high otherwise. Setting a polarity parameter to 1 inverts that sync.
- R9: When `pix_en` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable; the position advances on cycles where this is high |
| pix_in | input | 8 | Colour for the next position: RRRGGGBB |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hcount_o | output | 10 | Current column |
| vcount_o | output | 10 | Current row |
| active_o | output | 1 | High inside the visible area |
| pix_out_o | output | 8 | Colour, forced to black outside the visible area |

## Verification
A wrong column or row count shows on `hcount_o` and `vcount_o` on the very next enabled edge. It also makes sync and blanking edges land in the wrong columns and rows. A corrupted sync or visibility register shows at the ports immediately, because these outputs are the registers themselves. A fault in the line-to-frame carry only appears when a line ends, so the bench also uses a small-geometry instance that wraps whole frames many times. That instance is paired with a full-size instance that checks real line timing with sparse and irregular enables.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;
  localparam int COLOUR_W = 8;
  localparam int RED_W    = 3;
  localparam int GREEN_W  = 3;
  localparam int BLUE_W   = 2;

  function automatic logic in_span(input int pos, input int lo, input int hi);
    return (pos >= lo) && (pos < hi);
  endfunction
endpackage

// File: rtl/vga_axis_ctr.sv
module vga_axis_ctr
  import vga_raster_pkg::*;
#(
  parameter int   ACTIVE   = 640,
  parameter int   FRONT    = 16,
  parameter int   SYNC     = 96,
  parameter int   BACK     = 48,
  parameter int   CNT_W    = 10,
  parameter logic SYNC_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             vis_nx_o,
  output logic             sync_o
);
  localparam int TOTAL   = ACTIVE + FRONT + SYNC + BACK;
  localparam int SYNC_LO = ACTIVE + FRONT;
  localparam int SYNC_HI = SYNC_LO + SYNC;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL - 1);
  localparam logic RST_SYNC = in_span(TOTAL - 1, SYNC_LO, SYNC_HI) ? SYNC_LVL : ~SYNC_LVL;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             sync_q;

  assign last_o = (cnt_q == LAST_C);
  assign cnt_nx = last_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= LAST_C;
      sync_q <= RST_SYNC;
    end else if (step) begin
      cnt_q  <= cnt_nx;
      sync_q <= in_span(int'(cnt_nx), SYNC_LO, SYNC_HI) ? SYNC_LVL : ~SYNC_LVL;
    end
  end

  // visibility of the position this counter will hold after the edge
  assign vis_nx_o = step ? (int'(cnt_nx) < ACTIVE) : (int'(cnt_q) < ACTIVE);
  assign cnt_o    = cnt_q;
  assign sync_o   = sync_q;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < TOTAL);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_o) |=> (cnt_q == '0));

  p_hold_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  p_sync_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == (in_span(int'(cnt_q), SYNC_LO, SYNC_HI) ? SYNC_LVL : ~SYNC_LVL));
endmodule

// File: rtl/vga_colour_gate.sv
module vga_colour_gate
  import vga_raster_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                show,
  input  logic [COLOUR_W-1:0] pix_i,
  output logic [COLOUR_W-1:0] pix_o
);
  logic [COLOUR_W-1:0] pix_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pix_q <= '0;
    else if (step) pix_q <= show ? pix_i : '0;
  end

  assign pix_o = pix_q;

  p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pix_q));
endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int   H_ACTIVE  = 640,
  parameter int   H_FRONT   = 16,
  parameter int   H_SYNC    = 96,
  parameter int   H_BACK    = 48,
  parameter int   V_ACTIVE  = 480,
  parameter int   V_FRONT   = 10,
  parameter int   V_SYNC    = 2,
  parameter int   V_BACK    = 33,
  parameter int   CNT_W     = 10,
  parameter logic HSYNC_LVL = 1'b0,
  parameter logic VSYNC_LVL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_en,
  input  logic [COLOUR_W-1:0] pix_in,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic [CNT_W-1:0]    hcount_o,
  output logic [CNT_W-1:0]    vcount_o,
  output logic                active_o,
  output logic [COLOUR_W-1:0] pix_out_o
);
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic h_last, v_last, h_vnx, v_vnx, h_sync, v_sync;
  logic v_step, show_nx, act_q;

  assign v_step  = pix_en & h_last;
  assign show_nx = h_vnx & v_vnx;

  vga_axis_ctr #(
    .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK),
    .CNT_W(CNT_W), .SYNC_LVL(HSYNC_LVL)
  ) u_hctr (
    .clk(clk), .rst_n(rst_n), .step(pix_en),
    .cnt_o(h_cnt), .last_o(h_last), .vis_nx_o(h_vnx), .sync_o(h_sync)
  );

  vga_axis_ctr #(
    .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK),
    .CNT_W(CNT_W), .SYNC_LVL(VSYNC_LVL)
  ) u_vctr (
    .clk(clk), .rst_n(rst_n), .step(v_step),
    .cnt_o(v_cnt), .last_o(v_last), .vis_nx_o(v_vnx), .sync_o(v_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (pix_en) act_q <= show_nx;
  end

  vga_colour_gate u_gate (
    .clk(clk), .rst_n(rst_n), .step(pix_en), .show(show_nx),
    .pix_i(pix_in), .pix_o(pix_out_o)
  );

  assign hsync_o  = h_sync;
  assign vsync_o  = v_sync;
  assign hcount_o = h_cnt;
  assign vcount_o = v_cnt;
  assign active_o = act_q;

  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !h_last) |=> $stable(vcount_o));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && h_last && v_last) |=> (hcount_o == '0 && vcount_o == '0));

  p_active_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (int'(hcount_o) < H_ACTIVE && int'(vcount_o) < V_ACTIVE));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (pix_out_o == '0));

  p_vsync_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_o) |-> (hcount_o == '0));

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({hsync_o, vsync_o, active_o, pix_out_o}));
endmodule

// File: tb/tb_vga_raster_gen.sv
module tb_vga_raster_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] pix_in = 8'h00;

  always #10 clk = ~clk;

  logic       hs0, vs0, ac0, hs1, vs1, ac1;
  logic [9:0] hc0, vc0, hc1, vc1;
  logic [7:0] px0, px1;

  vga_raster_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
    .hsync_o(hs0), .vsync_o(vs0), .hcount_o(hc0), .vcount_o(vc0),
    .active_o(ac0), .pix_out_o(px0)
  );

  // small geometry, positive syncs: H 8/2/3/2 = 15, V 4/1/2/2 = 9
  vga_raster_gen #(
    .H_ACTIVE(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
    .V_ACTIVE(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(2),
    .CNT_W(10), .HSYNC_LVL(1'b1), .VSYNC_LVL(1'b1)
  ) dut_s (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
    .hsync_o(hs1), .vsync_o(vs1), .hcount_o(hc1), .vcount_o(vc1),
    .active_o(ac1), .pix_out_o(px1)
  );

  int total = 0;
  int bad = 0;
  bit chk_on = 0;
  int hp0 = 799, vp0 = 524, hp1 = 14, vp1 = 8;
  logic [7:0] ep0 = 8'h00, ep1 = 8'h00;

  task automatic adv(inout int hp, inout int vp, inout logic [7:0] px,
                     input int ha, input int ht, input int va, input int vt,
                     input logic [7:0] cin);
    if (hp == ht - 1) begin
      hp = 0;
      vp = (vp == vt - 1) ? 0 : vp + 1;
    end else begin
      hp = hp + 1;
    end
    px = (hp < ha && vp < va) ? cin : 8'h00;
  endtask

  // reference model, updated on every edge
  always @(posedge clk) begin
    chk_on <= 1'b1;
    if (!rst_n) begin
      hp0 = 799; vp0 = 524; ep0 = 8'h00;
      hp1 = 14;  vp1 = 8;   ep1 = 8'h00;
    end else if (pix_en) begin
      adv(hp0, vp0, ep0, 640, 800, 480, 525, pix_in);
      adv(hp1, vp1, ep1, 8, 15, 4, 9, pix_in);
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic int lvl(input bit in_win, input bit act_lvl);
    return in_win ? int'(act_lvl) : int'(!act_lvl);
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 hcount full", int'(hc0), hp0);
      chk("R3 vcount full", int'(vc0), vp0);
      chk("R4/R8 hsync full", int'(hs0), lvl(hp0 >= 656 && hp0 < 752, 1'b0));
      chk("R5/R8 vsync full", int'(vs0), lvl(vp0 >= 490 && vp0 < 492, 1'b0));
      chk("R6 active full", int'(ac0), int'(hp0 < 640 && vp0 < 480));
      chk("R7 pix full", int'(px0), int'(ep0));
      chk("R2 hcount small", int'(hc1), hp1);
      chk("R3 vcount small", int'(vc1), vp1);
      chk("R4/R8 hsync small", int'(hs1), lvl(hp1 >= 10 && hp1 < 13, 1'b1));
      chk("R5/R8 vsync small", int'(vs1), lvl(vp1 >= 5 && vp1 < 7, 1'b1));
      chk("R6 active small", int'(ac1), int'(hp1 < 8 && vp1 < 4));
      chk("R7 pix small", int'(px1), int'(ep1));
    end
  end

  task automatic reset_check;
    chk("R1 hcount", int'(hc0), 799);
    chk("R1 vcount", int'(vc0), 524);
    chk("R1 hsync", int'(hs0), 1);
    chk("R1 vsync", int'(vs0), 1);
    chk("R1 active", int'(ac0), 0);
    chk("R1 pix", int'(px0), 0);
    chk("R1 small hsync", int'(hs1), 0);
  endtask

  task automatic drive(input logic en, input logic [7:0] c);
    @(negedge clk);
    #2;
    pix_en = en;
    pix_in = c;
  endtask

  logic [7:0] lf = 8'hA5;
  int hold_h;
  int hold_v;

  initial begin
    repeat (3) @(negedge clk);
    #3 reset_check();
    drive(1'b0, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) drive(1'b1, 8'(i * 37 + 5));
    for (int i = 0; i < 600; i++) drive(1'(i % 2), 8'(i * 11 + 1));
    drive(1'b0, 8'hFF);
    @(negedge clk);
    #3 hold_h = int'(hc0);
    hold_v = int'(vc1);
    for (int i = 0; i < 20; i++) drive(1'b0, 8'(i + 200));
    @(negedge clk);
    #3 chk("R9 hold hcount", int'(hc0), hold_h);
    chk("R9 hold small vcount", int'(vc1), hold_v);
    for (int i = 0; i < 600; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      drive(lf[0] | lf[3], lf ^ 8'(i));
    end
    drive(1'b1, 8'hFF);
    rst_n = 1'b0;
    repeat (2) drive(1'b1, 8'hFF);
    @(negedge clk);
    #3 reset_check();
    drive(1'b1, 8'hE3);
    rst_n = 1'b1;
    for (int i = 0; i < 2500; i++) drive(1'b1, (i % 5 == 0) ? 8'hFF : 8'(i * 29));
    @(negedge clk);
    #3 $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule